// File: doc/BRIEF.md
# Packet-Granular Round-Robin Stream Merger

This block merges several packet streams into a single output stream. Each input carries a wide data word and a narrow control byte, qualified by a write strobe, and each input gets its own ready line back. The default build has eight inputs. Four of them are normally fed by Ethernet receive paths and four by the host. The block grants one input at a time and passes that input's words straight through, with no added latency, until the packet ends. Only then does it release the grant and consider the other inputs.

Packet framing is read from the control byte. A packet opens with one or more header words whose control byte is nonzero. Body words follow, and their control byte is zero. The packet closes with a word whose control byte is nonzero again. The block therefore treats a nonzero control byte as an end marker only after it has seen a zero control byte in the same packet. Inputs are served in round-robin order, starting after the one served last, and idle inputs are skipped.

Top module: `pkt_merge_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every in_rdy bit and out_wr are low.
- R2: At most one in_rdy bit is high at any time, and it is high only while out_rdy is high.
- R3: Each word leaves on out_data and out_ctrl exactly as the granted input presented it. No word is added, dropped or changed.
- R4: out_wr is high in exactly the cycles in which the granted input has in_wr high and its in_rdy is high.
- R5: The words of a packet leave back to back in order. No word of any other input appears between a packet's first and last word.
- R6: A nonzero control byte ends a packet only after a zero control byte has been seen in that packet. Any number of leading nonzero header words is carried without releasing the grant.
- R7: When the grant is free, the next input is the first requesting input, counting upward from the one after the last input served and wrapping around. Inputs with in_wr low are skipped.
- R8: After reset, the search starts at input 0.
- R9: A grant is taken on the clock edge after the block is idle and sees a request, so the first word moves in the cycle after that. The grant is dropped on the edge where the last word moves.
- R10: While out_rdy is low, no word moves and the grant is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | N*DW | Data word of each input, input i at bits [i*DW +: DW] |
| in_ctrl | input | N*CW | Control byte of each input, input i at bits [i*CW +: CW] |
| in_wr | input | N | Per-input word-valid strobe |
| in_rdy | output | N | Per-input ready, high only for the granted input |
| out_data | output | DW | Merged data word |
| out_ctrl | output | CW | Merged control byte |
| out_wr | output | 1 | Merged word-valid strobe |
| out_rdy | input | 1 | Downstream ready |

## Verification
Two events can fall in the same cycle: the grant being released on a packet's last word, and other inputs requesting. The bench keeps every competing queue loaded while a packet drains, so the next choice is made at the exact edge where the old grant ends. It judges that choice by the sequence of packet starts on the output. Downstream stalls are also placed on a packet's final word, to show that the end marker counts only when the word actually moves. Source gaps in the middle of a packet show that an idle strobe neither ends the packet nor lets another input in.

// File: rtl/pkt_merge_arb.sv
module pkt_merge_arb #(
  parameter int N  = 8,
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*DW-1:0] in_data,
  input  logic [N*CW-1:0] in_ctrl,
  input  logic [N-1:0]    in_wr,
  output logic [N-1:0]    in_rdy,
  output logic [DW-1:0]   out_data,
  output logic [CW-1:0]   out_ctrl,
  output logic            out_wr,
  input  logic            out_rdy
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          busy;
  logic          seen_body;
  logic [IW-1:0] gnt;
  logic [IW-1:0] ptr;
  logic [IW-1:0] sel;
  logic          found;
  logic          xfer;
  logic          last;
  logic [CW-1:0] cur_ctrl;

  always_comb begin
    found = 1'b0;
    sel   = ptr;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && in_wr[idx]) begin
        found = 1'b1;
        sel   = IW'(idx);
      end
    end
  end

  assign cur_ctrl = in_ctrl[gnt*CW +: CW];
  assign xfer     = busy && in_wr[gnt] && out_rdy;
  assign last     = xfer && (cur_ctrl != '0) && seen_body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      gnt       <= '0;
      ptr       <= '0;
      seen_body <= 1'b0;
    end else begin
      if (!busy && found) begin
        busy <= 1'b1;
        gnt  <= sel;
        ptr  <= IW'((int'(sel) + 1) % N);
      end else if (last) begin
        busy <= 1'b0;
      end
      if (last)
        seen_body <= 1'b0;
      else if (xfer && cur_ctrl == '0)
        seen_body <= 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assign in_rdy[i] = busy && (gnt == IW'(i)) && out_rdy;
  end

  assign out_data = in_data[gnt*DW +: DW];
  assign out_ctrl = cur_ctrl;
  assign out_wr   = xfer;
endmodule

module pkt_merge_arb_chk #(
  parameter int N  = 8,
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*DW-1:0] in_data,
  input logic [N*CW-1:0] in_ctrl,
  input logic [N-1:0]    in_wr,
  input logic [N-1:0]    in_rdy,
  input logic [DW-1:0]   out_data,
  input logic [CW-1:0]   out_ctrl,
  input logic            out_wr,
  input logic            out_rdy
);
  logic [DW-1:0] exp_d;
  logic [CW-1:0] exp_c;
  logic [N-1:0]  held;
  logic          in_pkt;
  logic          body;

  always_comb begin
    exp_d = '0;
    exp_c = '0;
    for (int i = 0; i < N; i++) begin
      if (in_rdy[i]) begin
        exp_d = exp_d | in_data[i*DW +: DW];
        exp_c = exp_c | in_ctrl[i*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      in_pkt <= 1'b0;
      body   <= 1'b0;
    end else if (out_wr) begin
      held <= in_rdy;
      if (out_ctrl == '0) begin
        body   <= 1'b1;
        in_pkt <= 1'b1;
      end else if (body) begin
        body   <= 1'b0;
        in_pkt <= 1'b0;
      end else begin
        in_pkt <= 1'b1;
      end
    end
  end

  always @(negedge clk)
    if (!rst_n) p_reset_idle_r1: assert (in_rdy == '0 && !out_wr);

  p_first_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_rdy == '0 && !out_wr));
  p_one_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_rdy));
  p_rdy_needs_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy != '0) |-> out_rdy);
  p_pass_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> (out_data == exp_d && out_ctrl == exp_c));
  p_wr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr == ((in_wr & in_rdy) != '0));
  p_no_interleave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && in_rdy != '0) |-> (in_rdy == held));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |-> !out_wr);
endmodule

bind pkt_merge_arb pkt_merge_arb_chk #(.N(N), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/pkt_merge_arb_tb.sv
module pkt_merge_arb_tb;
  localparam int N = 8, DW = 64, CW = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [N*DW-1:0] in_data = '0;
  logic [N*CW-1:0] in_ctrl = '0;
  logic [N-1:0]    in_wr = '0;
  logic [N-1:0]    in_rdy;
  logic [DW-1:0]   out_data;
  logic [CW-1:0]   out_ctrl;
  logic            out_wr;
  logic            out_rdy = 1;

  pkt_merge_arb #(.N(N), .DW(DW), .CW(CW)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int plen[N], pos[N], pnum[N];
  int hdrs = 2;
  int cyc = 0;
  int stall_lo = -1, stall_hi = -1;
  bit gap_mode = 0;
  int start_log[32];
  int nstart = 0;
  int cur_q = -1, exp_k = 0;
  bit in_pkt = 0;
  bit finished = 0;

  function automatic logic [7:0] ctrl_of(int k, int len);
    if (k < hdrs) return (k == 0) ? 8'hff : 8'(8'h04 + k);
    if (k == len - 1) return 8'h10;
    return 8'h00;
  endfunction

  function automatic logic [63:0] data_of(int q, int n, int k);
    return {8'(8'hA0 + q), 24'(n), 32'(k)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      if (pos[i] < plen[i] && !(gap_mode && ((cyc + i) % 3 == 0))) begin
        in_wr[i] = 1'b1;
        in_ctrl[i*CW +: CW] = ctrl_of(pos[i], plen[i]);
        in_data[i*DW +: DW] = data_of(i, pnum[i], pos[i]);
      end else begin
        in_wr[i] = 1'b0;
        in_ctrl[i*CW +: CW] = '0;
        in_data[i*DW +: DW] = '0;
      end
    end
    out_rdy = !(cyc >= stall_lo && cyc < stall_hi);
  endtask

  task automatic load(int q, int len);
    plen[q] = len;
    pos[q]  = 0;
    pnum[q]++;
  endtask

  task automatic step();
    logic [N-1:0] r, w;
    @(negedge clk);
    r = in_rdy;
    w = in_wr;
    chk($countones(r) <= 1 && (r == '0 || out_rdy), "R2", 64'(r), 64'(0));
    chk(out_wr == ((w & r) != '0), "R4", 64'(out_wr), 64'((w & r) != '0));
    if (!out_rdy) chk(!out_wr, "R10", 64'(out_wr), 64'(0));
    if (out_wr) begin
      int q, k;
      q = int'(out_data[63:56]) - 'hA0;
      k = int'(out_data[31:0]);
      if (q < 0 || q >= N) begin
        chk(0, "R3", out_data, 64'(0));
      end else begin
        if (k == 0) begin
          chk(!in_pkt, "R5", 64'(q), 64'(cur_q));
          if (nstart < 32) start_log[nstart] = q;
          nstart++;
          cur_q = q; exp_k = 0; in_pkt = 1;
        end
        chk(q == cur_q && k == exp_k, "R5", 64'(k), 64'(exp_k));
        chk(out_data == data_of(q, pnum[q], k) && out_ctrl == ctrl_of(k, plen[q]),
            "R3", {out_data[55:0], out_ctrl}, {data_of(q, pnum[q], k), ctrl_of(k, plen[q])});
        exp_k++;
        if (k == plen[q] - 1) in_pkt = 0;
      end
    end
    @(posedge clk);
    #2;
    for (int i = 0; i < N; i++) if (w[i] && r[i]) pos[i]++;
    cyc++;
    drive();
  endtask

  function automatic bit pending();
    for (int i = 0; i < N; i++) if (pos[i] < plen[i]) return 1;
    return in_pkt;
  endfunction

  task automatic drain();
    int guard = 0;
    while (pending() && guard < 2000) begin step(); guard++; end
    chk(!pending(), "R5", 64'(guard), 64'(0));
  endtask

  task automatic expect_order(string req, int n, int a0, int a1, int a2, int a3,
                              int a4, int a5, int a6, int a7);
    int e[8];
    e = '{a0, a1, a2, a3, a4, a5, a6, a7};
    chk(nstart == n, req, 64'(nstart), 64'(n));
    for (int i = 0; i < n && i < nstart; i++)
      chk(start_log[i] == e[i], req, 64'(start_log[i]), 64'(e[i]));
    nstart = 0;
  endtask

  task automatic t_reset();
    #5;
    chk(in_rdy == '0 && !out_wr, "R1", 64'(in_rdy), 64'(0));
    repeat (3) @(posedge clk);
    #2;
    for (int i = 0; i < N; i++) load(i, 5);
    drive();
    rst_n = 1;
    @(negedge clk);
    chk(in_rdy == '0 && !out_wr, "R1", 64'(in_rdy), 64'(0));
    @(posedge clk);
    #2;
  endtask

  task automatic t_all_rr();
    drain();
    expect_order("R8", 8, 0, 1, 2, 3, 4, 5, 6, 7);
  endtask

  task automatic t_skip();
    load(5, 6); load(2, 4); drive();
    drain();
    expect_order("R7", 2, 2, 5, 0, 0, 0, 0, 0, 0);
    load(3, 5); load(6, 5); drive();
    drain();
    expect_order("R7", 2, 6, 3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    repeat (2) step();
    load(3, 4); drive();
    @(negedge clk);
    chk(!out_wr && in_rdy == '0, "R9", 64'(in_rdy), 64'(0));
    @(posedge clk); #2;
    @(negedge clk);
    chk(out_wr && in_rdy == 8'b0000_1000, "R9", 64'(in_rdy), 64'h08);
    @(posedge clk); #2;
    cyc++;
    cur_q = 3; exp_k = 1; in_pkt = 1; pos[3] = 1; drive();
    drain();
    @(negedge clk);
    chk(!out_wr && in_rdy == '0, "R9", 64'(in_rdy), 64'(0));
    @(posedge clk); #2;
    nstart = 0;
  endtask

  task automatic t_headers();
    hdrs = 3;
    load(1, 6); load(4, 7); drive();
    drain();
    expect_order("R6", 2, 4, 1, 0, 0, 0, 0, 0, 0);
    hdrs = 2;
  endtask

  task automatic t_stall_gaps();
    gap_mode = 1;
    stall_lo = cyc + 3; stall_hi = cyc + 7;
    load(0, 8); load(7, 5); drive();
    drain();
    expect_order("R10", 2, 0, 7, 0, 0, 0, 0, 0, 0);
    gap_mode = 0;
    stall_lo = cyc + 5; stall_hi = cyc + 9;
    load(2, 5); load(4, 5); drive();
    drain();
    expect_order("R10", 2, 2, 4, 0, 0, 0, 0, 0, 0);
    stall_lo = -1; stall_hi = -1; drive();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin plen[i] = 0; pos[i] = 0; pnum[i] = 0; end
    t_reset();
    t_all_rr();
    t_skip();
    t_latency();
    t_headers();
    t_stall_gaps();
    repeat (3) step();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule